// File: doc/BRIEF.md
# Clock Generator Serial Configuration Slave

This block is the two-wire configuration port of a clock generator. A host on the SCL/SDA bus writes six 8-bit control bytes with block-write transactions and reads them back with block-read transactions. The six bytes are presented in parallel on `regs_o`, so the clock dividers, output enables and spread control can use them directly. SDA is driven through an open-drain enable: `sda_oe` high pulls the line low.

SCL and SDA are first re-timed to the system clock by a short flop chain. Start and stop conditions and SCL edges are then found in the re-timed signals. A write carries two leading bytes, a command and a count, which are acknowledged and thrown away. The data bytes that follow always fill the registers from byte 0 upward, because there is no register pointer. A read returns a fixed byte count and then every register in order. One enable bit is hidden on readback while it still drives the chip.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset `regs_o` is 48'h00_00_00_FF_FF_1F. Byte k occupies bits [8k+7:8k], so byte 0 = 1Fh, bytes 1 and 2 = FFh, and bytes 3, 4 and 5 = 00h.
- R2: The slave acknowledges the address byte D2h (7-bit address 69h with R/W = 0), the command byte and the count byte. The command and count values are discarded. Each following data byte is acknowledged and stored in registers 0, 1, 2 and so on, in that order. Bits are sent MSB first.
- R3: A stop after any complete data byte ends the write. Registers already received keep their new values and the others keep their old values. The registers never change outside a received data byte.
- R4: A write data byte beyond the sixth is still acknowledged, and it changes no register.
- R5: The slave acknowledges the address byte D3h. It then sends the count 06h, followed by registers 0 to 5, MSB first. Each byte after the first is sent only if the host acknowledged the byte before it.
- R6: Bit 0 of register 0 always reads back as 0, while `regs_o[0]` keeps the stored value.
- R7: Any address byte other than D2h or D3h gets no acknowledge. The slave then leaves SDA released and the registers unchanged until the next start.
- R8: `sda_oe` changes only while SCL is low.
- R9: After the host sends a NACK during a read, the slave releases SDA until the next start condition.
- R10: A repeated start at any point, including in the middle of a byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 48 | Six control bytes, byte k at [8k+7:8k] |

## Verification
Full six-byte writes are compared with writes stopped after two bytes and writes running two bytes past the end. This separates "store in order" from "hold the bytes not reached" and from "discard the overflow". A full read uses a stored value with bit 0 of register 0 set, so a masked readback can be told apart from a masked register. Foreign addresses are sent with data bytes after them. A read is cut short by a NACK while the host keeps clocking. Repeated starts are placed both after a complete byte and in the middle of one. Together these show that the address decoder, the NACK release and the restart each act alone. A register image compared at every SCL-high clock catches any write that lands in the wrong byte or at the wrong time.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK,
        ST_SKIP
    } cfg_st_e;

    // Power-on value of control byte idx
    function automatic logic [7:0] reg_default(int idx);
        case (idx)
            0:       return 8'h1F;
            1, 2:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);

    typedef struct packed {
        logic [STAGES-1:0] scl_p;
        logic [STAGES-1:0] sda_p;
        logic              scl_l;
        logic              sda_l;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl_p = {q.scl_p[STAGES-2:0], scl_i};
        d.sda_p = {q.sda_p[STAGES-2:0], sda_i};
        d.scl_l = q.scl_p[STAGES-1];
        d.sda_l = q.sda_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s    = q.scl_p[STAGES-1];
    assign sda_s    = q.sda_p[STAGES-1];
    assign scl_rise = scl_s & ~q.scl_l;
    assign scl_fall = ~scl_s & q.scl_l;
    assign start_c  = scl_s & q.scl_l & q.sda_l & ~sda_s;
    assign stop_c   = scl_s & q.scl_l & ~q.sda_l & sda_s;

endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
    import cfgs_pkg::*;
#(
    parameter int             NREG      = 6,
    parameter int             DW        = 8,
    parameter int             RI_W      = $clog2(NREG),
    parameter int             ZERO_BYTE = 0,
    parameter logic [DW-1:0]  ZERO_MASK = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [RI_W-1:0]    widx,
    input  logic [DW-1:0]      wdata,
    input  logic [RI_W-1:0]    rd_idx,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs_o
);

    localparam int TOT = NREG * DW;
    localparam logic [RI_W:0] NREG_L = (RI_W+1)'(NREG);
    localparam logic [RI_W-1:0] ZB_L = RI_W'(ZERO_BYTE);

    function automatic logic [TOT-1:0] build_default();
        logic [TOT-1:0] v;
        v = '0;
        for (int i = 0; i < NREG; i++) v[i*DW +: DW] = DW'(reg_default(i));
        return v;
    endfunction

    localparam logic [TOT-1:0] RST_VAL = build_default();

    logic [TOT-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && ({1'b0, widx} < NREG_L))
            regs_d[int'(widx)*DW +: DW] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_VAL;
        else        regs_q <= regs_d;
    end

    // Readback path: one configured bit is hidden
    always_comb begin
        rd_data = '0;
        if ({1'b0, rd_idx} < NREG_L) begin
            rd_data = regs_q[int'(rd_idx)*DW +: DW];
            if (rd_idx == ZB_L) rd_data = rd_data & ~ZERO_MASK;
        end
    end

    assign regs_o = regs_q;

    // R4: the control logic never addresses a byte beyond the file
    a_r4_widx_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, widx} < NREG_L));

    // R3: contents move only on a write strobe
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q));

endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
    import cfgs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NREG        = 6,
    parameter int         HDR         = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);

    localparam int DW    = 8;
    localparam int IDX_W = $clog2(HDR + NREG + 1);
    localparam int RI_W  = $clog2(NREG);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR + NREG);
    localparam logic [IDX_W-1:0] HDR_I    = IDX_W'(HDR);
    localparam logic [IDX_W-1:0] NREG_I   = IDX_W'(NREG);
    localparam logic [DW-1:0]    CNT_BYTE = DW'(NREG);
    localparam logic [DW-1:0]    WR_ADDR  = {DEV_ADDR, 1'b0};
    localparam logic [DW-1:0]    RD_ADDR  = {DEV_ADDR, 1'b1};

    typedef struct packed {
        cfg_st_e          st;
        logic [2:0]       bit_n;
        logic             full;
        logic [DW-1:0]    sh;
        logic [IDX_W-1:0] idx;
        logic             rd;
        logic             oe;
        logic             hack;
    } fsm_t;

    fsm_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic            we;
    logic [RI_W-1:0] widx;
    logic [RI_W-1:0] rd_idx;
    logic [DW-1:0]   rd_data;
    logic [IDX_W-1:0] sel;
    logic [DW-1:0]   tx_byte;

    cfgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    cfgs_regfile #(.NREG(NREG), .DW(DW), .RI_W(RI_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .widx    (widx),
        .wdata   (q.sh),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

    // Byte to send next: index 0 is the count, k>0 is register k-1
    always_comb begin
        sel     = (q.st == ST_HACK) ? q.idx + 1'b1 : q.idx;
        rd_idx  = RI_W'(sel - 1'b1);
        tx_byte = (sel == '0) ? CNT_BYTE : rd_data;
    end

    always_comb begin
        d    = q;
        we   = 1'b0;
        widx = RI_W'(q.idx - HDR_I);
        if (start_c) begin
            d.st    = ST_ADDR;
            d.bit_n = '0;
            d.full  = 1'b0;
            d.oe    = 1'b0;
        end else if (stop_c) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        d.sh    = {q.sh[DW-2:0], sda_s};
                        d.bit_n = q.bit_n + 1'b1;
                        if (q.bit_n == 3'd7) d.full = 1'b1;
                    end else if (scl_fall && q.full) begin
                        d.full  = 1'b0;
                        d.bit_n = '0;
                        if (q.st == ST_ADDR) begin
                            d.idx = '0;
                            if (q.sh == WR_ADDR) begin
                                d.st = ST_ACK;
                                d.oe = 1'b1;
                                d.rd = 1'b0;
                            end else if (q.sh == RD_ADDR) begin
                                d.st = ST_ACK;
                                d.oe = 1'b1;
                                d.rd = 1'b1;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else begin
                            d.st = ST_ACK;
                            d.oe = 1'b1;
                            if (q.idx >= HDR_I && q.idx < IDX_LAST) we = 1'b1;
                            if (q.idx != IDX_LAST) d.idx = q.idx + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bit_n = '0;
                        d.full  = 1'b0;
                        if (q.rd) begin
                            d.st = ST_TX;
                            d.sh = tx_byte;
                            d.oe = ~tx_byte[DW-1];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bit_n == 3'd7) begin
                            d.st = ST_HACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh    = {q.sh[DW-2:0], 1'b0};
                            d.oe    = ~q.sh[DW-2];
                            d.bit_n = q.bit_n + 1'b1;
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        d.hack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.hack && q.idx < NREG_I) begin
                            d.idx   = q.idx + 1'b1;
                            d.st    = ST_TX;
                            d.sh    = tx_byte;
                            d.oe    = ~tx_byte[DW-1];
                            d.bit_n = '0;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

    // R8: the drive enable is steady through every SCL-high span
    a_r8_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !scl_rise) |-> $stable(sda_oe));

    // R10: a start seen anywhere returns to address reception
    a_r10_restart_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (q.st == ST_ADDR && !sda_oe));

    // R7: a foreign address never draws an acknowledge
    a_r7_no_ack_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && q.full && scl_fall && !start_c && !stop_c &&
         q.sh[DW-1:1] != DEV_ADDR) |=> !sda_oe);

    // R9: after a declined byte the line stays released
    a_r9_release_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP && !start_c) |=> !sda_oe);

endmodule

// File: tb/sim_clkgen_cfg_slave.sv
module sim_clkgen_cfg_slave;

    localparam int HP = 25;   // SCL half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl;
    logic        host_sda;
    logic        sda_line;
    logic        sda_oe;
    logic [47:0] regs_o;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_line = host_sda & ~sda_oe;

    clkgen_cfg_slave u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    int         n_chk  = 0;
    int         n_fail = 0;
    int         viol   = 0;
    bit         done   = 0;
    bit         oe_seen = 0;
    logic       prev_scl = 1'b1;
    logic       prev_oe  = 1'b0;
    logic [7:0] model [6];

    function automatic logic [47:0] model_vec();
        logic [47:0] v;
        for (int i = 0; i < 6; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference register image compared at every SCL-high clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (scl) check("R2/R3/R4 register image", regs_o, model_vec());
            if (scl && prev_scl && (sda_oe !== prev_oe)) viol++;
            if (sda_oe) oe_seen = 1;
            prev_scl = scl;
            prev_oe  = sda_oe;
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1;
        wait_clk(HP);
        scl = 1'b1;
        wait_clk(HP);
        host_sda = 1'b0;
        wait_clk(HP);
        scl = 1'b0;
        wait_clk(4);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0;
        wait_clk(HP - 4);
        scl = 1'b1;
        wait_clk(HP);
        host_sda = 1'b1;
        wait_clk(HP);
    endtask

    task automatic bit_io(input logic b, output logic r);
        host_sda = b;
        wait_clk(HP - 4);
        scl = 1'b1;
        wait_clk(HP - 3);
        r = sda_line;
        wait_clk(3);
        scl = 1'b0;
        wait_clk(4);
    endtask

    // midx >= 0: model stores the byte in that register before the ack clock
    task automatic send_byte(input logic [7:0] b, input int midx, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r);
        if (midx >= 0 && midx < 6) model[midx] = b;
        bit_io(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            v[i] = r;
        end
        bit_io(~host_ack, r);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) model[i] = 8'h00;
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        logic [7:0] wdat [8];
        rst_n    = 1'b0;
        scl      = 1'b1;
        host_sda = 1'b1;
        model[0] = 8'h1F; model[1] = 8'hFF; model[2] = 8'hFF;
        model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h00;
        wait_clk(10);
        check("R1 reset image", regs_o, 48'h0000_00FF_FF1F);
        check("R1 sda released in reset", {47'd0, sda_oe}, 48'd0);
        rst_n = 1'b1;
        wait_clk(10);

        // Full six-byte write
        wdat[0] = 8'h3D; wdat[1] = 8'hA5; wdat[2] = 8'h5A;
        wdat[3] = 8'hC3; wdat[4] = 8'h81; wdat[5] = 8'h7E;
        bus_start();
        send_byte(8'hD2, -1, ack); check("R2 write address ack", {47'd0, ack}, 48'd1);
        send_byte(8'h12, -1, ack); check("R2 command ack", {47'd0, ack}, 48'd1);
        send_byte(8'h34, -1, ack); check("R2 count ack", {47'd0, ack}, 48'd1);
        for (int i = 0; i < 6; i++) begin
            send_byte(wdat[i], i, ack);
            check("R2 data ack", {47'd0, ack}, 48'd1);
        end
        bus_stop();
        check("R2 stored image", regs_o, 48'h7E81_C35A_A53D);

        // Full read back
        bus_start();
        send_byte(8'hD3, -1, ack); check("R5 read address ack", {47'd0, ack}, 48'd1);
        recv_byte(1'b1, v); check("R5 count byte", {40'd0, v}, 48'h06);
        for (int i = 0; i < 6; i++) begin
            recv_byte(i != 5, v);
            if (i == 0) check("R6 masked readback", {40'd0, v}, {40'd0, model[0] & 8'hFE});
            else        check("R5 readback byte", {40'd0, v}, {40'd0, model[i]});
        end
        bus_stop();
        check("R6 stored bit kept", {47'd0, regs_o[0]}, 48'd1);

        // Write stopped after two data bytes
        bus_start();
        send_byte(8'hD2, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h11, 0, ack);
        send_byte(8'h22, 1, ack);
        bus_stop();
        check("R3 partial write", regs_o, 48'h7E81_C35A_2211);

        // Write past the last register
        for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h90 + i);
        bus_start();
        send_byte(8'hD2, -1, ack);
        send_byte(8'hFF, -1, ack);
        send_byte(8'hFF, -1, ack);
        for (int i = 0; i < 8; i++) begin
            send_byte(wdat[i], i, ack);
            if (i >= 6) check("R4 overflow ack", {47'd0, ack}, 48'd1);
        end
        bus_stop();
        check("R4 overflow discarded", regs_o, 48'h9594_9392_9190);

        // Foreign addresses
        oe_seen = 0;
        bus_start();
        send_byte(8'hA4, -1, ack); check("R7 foreign address nack", {47'd0, ack}, 48'd0);
        send_byte(8'h00, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h55, -1, ack);
        bus_stop();
        bus_start();
        send_byte(8'hD5, -1, ack); check("R7 foreign read nack", {47'd0, ack}, 48'd0);
        bus_stop();
        check("R7 line untouched", {47'd0, oe_seen}, 48'd0);
        check("R7 registers untouched", regs_o, 48'h9594_9392_9190);

        // NACK cuts a read short
        bus_start();
        send_byte(8'hD3, -1, ack);
        recv_byte(1'b1, v);
        recv_byte(1'b0, v); check("R9 byte before nack", {40'd0, v}, 48'h90);
        oe_seen = 0;
        recv_byte(1'b0, v); check("R9 released after nack", {40'd0, v}, 48'hFF);
        bus_stop();
        check("R9 no drive after nack", {47'd0, oe_seen}, 48'd0);

        // Repeated start after a full byte
        bus_start();
        send_byte(8'hD2, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h77, 0, ack);
        bus_start();
        send_byte(8'hD2, -1, ack); check("R10 restart address ack", {47'd0, ack}, 48'd1);
        send_byte(8'h00, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h88, 0, ack);
        bus_stop();
        check("R10 restart writes byte 0", {40'd0, regs_o[7:0]}, 48'h88);

        // Repeated start in the middle of a byte
        bus_start();
        send_byte(8'hD2, -1, ack);
        for (int i = 0; i < 4; i++) bit_io(1'b0, ack);
        bus_start();
        send_byte(8'hD3, -1, ack); check("R10 mid-byte restart ack", {47'd0, ack}, 48'd1);
        recv_byte(1'b0, v); check("R10 count after restart", {40'd0, v}, 48'h06);
        bus_stop();

        check("R8 drive steady while SCL high", 48'(viol), 48'd0);
        report();
    end

endmodule